// File: doc/BRIEF.md
# Flash Command-Mode Controller

This block follows the operating mode of a flash device from the stream of write cycles the host presents to it. Each accepted write carries an address and a byte. A short stepper matches the writes against a parameterised unlock-and-command table. It then moves the controller between these modes:

- array reading
- identifier (autoselect) reading
- running program
- running erase
- erase suspended
- program inside a suspension
- failed
- sequence error

Completion and failure pulses from a separate embedded-algorithm engine end the running operations. That engine reads the `mode` output to know what to run.

On the read side the block does not carry data. For any read address it produces a route code that tells the data path whether to return array contents, status bits or identifier bytes.

- **Erase suspension.** The route is decided per sector from a bitmap of sectors whose erase is pending. Reads inside such a sector return status. Reads elsewhere return array contents.
- **Supply lockout.** A low `supply_ok` acts as an internal reset. It also withdraws write acceptance.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: While `rst_n` is low, and on every clock edge at which `supply_ok` is low, the mode becomes read-array. The pending-sector bitmap is cleared. `wr_ready` equals `supply_ok`, and a write offered while `wr_ready` is low has no effect on any state.
- R2: In read-array mode (`mode` = 0), `rd_route` is 0 (array) for every read address.
- R3: The writes AA@555h, 55@2AAh, 90@555h (data@address) made in read-array mode select identifier mode (`mode` = 1) with `rd_route` = 2. In that mode every write other than data F0h is ignored. Data F0h at any address returns to read-array.
- R4: The writes AA@555h, 55@2AAh, A0@555h, followed by one write of any address and any data other than F0h, start a program (`mode` = 2), during which `rd_route` = 1. An `op_done` pulse without `op_fail` returns to read-array.
- R5: The writes AA@555h, 55@2AAh, 80@555h, AA@555h, 55@2AAh, then 30h at an address start an erase (`mode` = 3). The erase marks the sector given by the top `SECT_BITS` address bits of that last write. Ending the last write with 10h@555h instead marks every sector. `op_done` returns to read-array and clears every mark.
- R6: During an erase, a write of B0h at any address gives erase-suspended (`mode` = 4). There, `rd_route` is 1 for addresses in marked sectors and 0 for all others. A write of 30h with no sequence in progress resumes the erase (`mode` = 3).
- R7: In erase-suspended mode the program sequence of R4 gives program-in-suspend (`mode` = 5), with `rd_route` = 1 everywhere. `op_done` returns to erase-suspended with the same marks and routing as before.
- R8: `op_fail` in program, erase or program-in-suspend gives the failed mode (`mode` = 6), even when `op_done` is high in the same cycle. While a program or erase is running, data F0h is ignored. In the failed mode `rd_route` = 1, and only data F0h leaves it, to read-array.
- R9: In read-array or erase-suspended mode, a write whose address or data does not match the next expected step gives the error mode (`mode` = 7), with `rd_route` = 1. Only data F0h leaves it, to read-array, clearing every mark.
- R10: Data F0h written part way through a sequence abandons it. The mode stays read-array, or stays erase-suspended, and the next write must begin a sequence afresh.
- R11: `op_done` and `op_fail` have no effect in read-array, identifier, erase-suspended, failed and error modes.
- R12: `mode` changes on the clock edge that accepts the write or pulse causing it. `rd_route` follows `rd_addr` and `mode` without a clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_ok | input | 1 | Supply above lockout level; low forces an internal reset |
| wr_valid | input | 1 | Write cycle offered |
| wr_ready | output | 1 | Write cycle accepted when high together with `wr_valid`; low only during lockout |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| op_done | input | 1 | Embedded operation finished (one-cycle pulse) |
| op_fail | input | 1 | Embedded operation failed (one-cycle pulse) |
| rd_addr | input | ADDR_W | Address of the current read |
| rd_route | output | 2 | Read source: 0 array, 1 status, 2 identifier |
| mode | output | 3 | Operating mode code as listed in the requirements |

Back-pressure rule: there is no buffering. A write is taken on any edge where `wr_valid` and `wr_ready` are both high. `wr_ready` drops only while the supply is locked out, and writes offered then are dropped rather than held.

## Verification
A wrong stepper position shows up one edge after the next write. Either a correct sequence lands in the error mode, or a broken one escapes it, and the `mode` port shows this at once. A wrong bit in the pending-sector bitmap is not visible while the erase runs, because every read routes to status then. It surfaces only after a suspend, as a wrong `rd_route` for that one sector. For that reason the bench suspends every possible erase target and sweeps every sector. A mode register that fails to hold in the failed or error mode shows as a `mode` change on the first unrelated write or pulse.

// File: rtl/fcm_pkg.sv
package fcm_pkg;
  typedef enum logic [2:0] {
    MD_READ  = 3'd0,
    MD_IDENT = 3'd1,
    MD_PROG  = 3'd2,
    MD_ERASE = 3'd3,
    MD_ESUSP = 3'd4,
    MD_PSUSP = 3'd5,
    MD_FAIL  = 3'd6,
    MD_ERROR = 3'd7
  } mode_t;

  typedef enum logic [1:0] {
    RT_ARRAY  = 2'd0,
    RT_STATUS = 2'd1,
    RT_IDENT  = 2'd2
  } route_t;

  typedef enum logic [2:0] {
    EV_NONE, EV_RESET, EV_IDENT, EV_PROG,
    EV_ERS_SECT, EV_ERS_CHIP, EV_RESUME, EV_BAD
  } ev_t;
endpackage

// File: rtl/fcm_seq.sv
module fcm_seq import fcm_pkg::*; #(
  parameter int ADDR_W = 11,
  parameter logic [ADDR_W-1:0] UNLOCK1_ADDR = 'h555,
  parameter logic [ADDR_W-1:0] UNLOCK2_ADDR = 'h2AA,
  parameter logic [7:0] UNLOCK1_DATA = 8'hAA,
  parameter logic [7:0] UNLOCK2_DATA = 8'h55,
  parameter logic [7:0] CMD_RESET = 8'hF0,
  parameter logic [7:0] CMD_IDENT = 8'h90,
  parameter logic [7:0] CMD_PROG = 8'hA0,
  parameter logic [7:0] CMD_ERASE_SETUP = 8'h80,
  parameter logic [7:0] CMD_SECT_ERASE = 8'h30,
  parameter logic [7:0] CMD_CHIP_ERASE = 8'h10,
  parameter logic [7:0] CMD_SUSPEND = 8'hB0,
  parameter logic [7:0] CMD_RESUME = 8'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic              in_susp,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output ev_t               ev
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_UNL, ST_CMD, ST_PDATA, ST_E_UNL1, ST_E_UNL2, ST_E_CMD
  } step_t;

  step_t step_q, step_d;
  logic  hit1, hit2;

  assign hit1 = (wr_addr == UNLOCK1_ADDR) && (wr_data == UNLOCK1_DATA);
  assign hit2 = (wr_addr == UNLOCK2_ADDR) && (wr_data == UNLOCK2_DATA);

  always_comb begin
    ev     = EV_NONE;
    step_d = step_q;
    if (wr_en) begin
      if (wr_data == CMD_RESET) begin
        ev = EV_RESET;
      end else begin
        unique case (step_q)
          ST_IDLE: begin
            if (hit1)                                 step_d = ST_UNL;
            else if (in_susp && wr_data == CMD_RESUME)  ev = EV_RESUME;
            else if (in_susp && wr_data == CMD_SUSPEND) ev = EV_NONE;
            else                                        ev = EV_BAD;
          end
          ST_UNL:    if (hit2) step_d = ST_CMD; else ev = EV_BAD;
          ST_CMD: begin
            if (wr_addr != UNLOCK1_ADDR)                    ev = EV_BAD;
            else if (wr_data == CMD_PROG)                   step_d = ST_PDATA;
            else if (!in_susp && wr_data == CMD_IDENT)      ev = EV_IDENT;
            else if (!in_susp && wr_data == CMD_ERASE_SETUP) step_d = ST_E_UNL1;
            else                                            ev = EV_BAD;
          end
          ST_PDATA:  ev = EV_PROG;
          ST_E_UNL1: if (hit1) step_d = ST_E_UNL2; else ev = EV_BAD;
          ST_E_UNL2: if (hit2) step_d = ST_E_CMD; else ev = EV_BAD;
          ST_E_CMD: begin
            if (wr_data == CMD_SECT_ERASE) ev = EV_ERS_SECT;
            else if (wr_addr == UNLOCK1_ADDR && wr_data == CMD_CHIP_ERASE) ev = EV_ERS_CHIP;
            else ev = EV_BAD;
          end
          default: ev = EV_BAD;
        endcase
      end
      if (ev != EV_NONE) step_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   step_q <= ST_IDLE;
    else if (clr) step_q <= ST_IDLE;
    else          step_q <= step_d;
  end
endmodule

// File: rtl/fcm_sector_map.sv
module fcm_sector_map #(
  parameter int SECT_BITS = 2,
  localparam int NSECT = 1 << SECT_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 set_one,
  input  logic                 set_all,
  input  logic [SECT_BITS-1:0] set_idx,
  input  logic [SECT_BITS-1:0] qry_idx,
  output logic                 hit
);
  logic [NSECT-1:0] pend_q;

  for (genvar i = 0; i < NSECT; i++) begin : g_sect
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pend_q[i] <= 1'b0;
      else if (clr) pend_q[i] <= 1'b0;
      else if (set_all || (set_one && set_idx == SECT_BITS'(i))) pend_q[i] <= 1'b1;
    end
  end

  assign hit = pend_q[qry_idx];
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl import fcm_pkg::*; #(
  parameter int ADDR_W = 11,
  parameter int SECT_BITS = 2,
  parameter logic [ADDR_W-1:0] UNLOCK1_ADDR = 'h555,
  parameter logic [ADDR_W-1:0] UNLOCK2_ADDR = 'h2AA,
  parameter logic [7:0] UNLOCK1_DATA = 8'hAA,
  parameter logic [7:0] UNLOCK2_DATA = 8'h55,
  parameter logic [7:0] CMD_RESET = 8'hF0,
  parameter logic [7:0] CMD_IDENT = 8'h90,
  parameter logic [7:0] CMD_PROG = 8'hA0,
  parameter logic [7:0] CMD_ERASE_SETUP = 8'h80,
  parameter logic [7:0] CMD_SECT_ERASE = 8'h30,
  parameter logic [7:0] CMD_CHIP_ERASE = 8'h10,
  parameter logic [7:0] CMD_SUSPEND = 8'hB0,
  parameter logic [7:0] CMD_RESUME = 8'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              op_done,
  input  logic              op_fail,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [1:0]        rd_route,
  output logic [2:0]        mode
);
  mode_t mode_q, mode_d;
  ev_t   ev;
  logic  wr_fire, is_rst, seq_en, seq_clr;
  logic  set_one, set_all, map_clr, map_hit;

  assign wr_ready = supply_ok;
  assign wr_fire  = wr_valid && supply_ok;
  assign is_rst   = wr_fire && (wr_data == CMD_RESET);
  assign seq_en   = wr_fire && (mode_q == MD_READ || mode_q == MD_ESUSP);
  assign seq_clr  = !supply_ok || !(mode_q == MD_READ || mode_q == MD_ESUSP);

  fcm_seq #(
    .ADDR_W(ADDR_W), .UNLOCK1_ADDR(UNLOCK1_ADDR), .UNLOCK2_ADDR(UNLOCK2_ADDR),
    .UNLOCK1_DATA(UNLOCK1_DATA), .UNLOCK2_DATA(UNLOCK2_DATA),
    .CMD_RESET(CMD_RESET), .CMD_IDENT(CMD_IDENT), .CMD_PROG(CMD_PROG),
    .CMD_ERASE_SETUP(CMD_ERASE_SETUP), .CMD_SECT_ERASE(CMD_SECT_ERASE),
    .CMD_CHIP_ERASE(CMD_CHIP_ERASE), .CMD_SUSPEND(CMD_SUSPEND), .CMD_RESUME(CMD_RESUME)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .clr(seq_clr), .wr_en(seq_en),
    .in_susp(mode_q == MD_ESUSP), .wr_addr(wr_addr), .wr_data(wr_data), .ev(ev)
  );

  always_comb begin
    mode_d  = mode_q;
    set_one = 1'b0;
    set_all = 1'b0;
    unique case (mode_q)
      MD_READ: begin
        unique case (ev)
          EV_IDENT:    mode_d = MD_IDENT;
          EV_PROG:     mode_d = MD_PROG;
          EV_ERS_SECT: begin mode_d = MD_ERASE; set_one = 1'b1; end
          EV_ERS_CHIP: begin mode_d = MD_ERASE; set_all = 1'b1; end
          EV_BAD:      mode_d = MD_ERROR;
          default:     mode_d = MD_READ;
        endcase
      end
      MD_IDENT: if (is_rst) mode_d = MD_READ;
      MD_PROG: begin
        if (op_fail)      mode_d = MD_FAIL;
        else if (op_done) mode_d = MD_READ;
      end
      MD_ERASE: begin
        if (op_fail)      mode_d = MD_FAIL;
        else if (op_done) mode_d = MD_READ;
        else if (wr_fire && wr_data == CMD_SUSPEND) mode_d = MD_ESUSP;
      end
      MD_ESUSP: begin
        unique case (ev)
          EV_PROG:   mode_d = MD_PSUSP;
          EV_RESUME: mode_d = MD_ERASE;
          EV_BAD:    mode_d = MD_ERROR;
          default:   mode_d = MD_ESUSP;
        endcase
      end
      MD_PSUSP: begin
        if (op_fail)      mode_d = MD_FAIL;
        else if (op_done) mode_d = MD_ESUSP;
      end
      default: if (is_rst) mode_d = MD_READ;
    endcase
  end

  assign map_clr = !supply_ok || (mode_d == MD_READ);

  fcm_sector_map #(.SECT_BITS(SECT_BITS)) u_map (
    .clk(clk), .rst_n(rst_n), .clr(map_clr), .set_one(set_one), .set_all(set_all),
    .set_idx(wr_addr[ADDR_W-1 -: SECT_BITS]), .qry_idx(rd_addr[ADDR_W-1 -: SECT_BITS]),
    .hit(map_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mode_q <= MD_READ;
    else if (!supply_ok) mode_q <= MD_READ;
    else                 mode_q <= mode_d;
  end

  always_comb begin
    unique case (mode_q)
      MD_READ:  rd_route = RT_ARRAY;
      MD_IDENT: rd_route = RT_IDENT;
      MD_ESUSP: rd_route = map_hit ? RT_STATUS : RT_ARRAY;
      default:  rd_route = RT_STATUS;
    endcase
  end

  assign mode = mode_q;
endmodule

// File: rtl/fcm_chk.sv
module fcm_chk #(
  parameter logic [7:0] CMD_RESET = 8'hF0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       supply_ok,
  input logic       wr_valid,
  input logic [7:0] wr_data,
  input logic       op_done,
  input logic       op_fail,
  input logic [1:0] rd_route,
  input logic [2:0] mode
);
  logic rst_wr, running;
  assign rst_wr  = wr_valid && wr_data == CMD_RESET;
  assign running = mode == 3'd2 || mode == 3'd3 || mode == 3'd5;

  AST_LOCKOUT_TO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> mode == 3'd0); // R1
  AST_READ_ROUTES_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 3'd0 |-> rd_route == 2'd0); // R2
  AST_IDENT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    supply_ok && mode == 3'd1 && !rst_wr |=> mode == 3'd1); // R3
  AST_PROG_DONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    supply_ok && mode == 3'd2 && op_done && !op_fail |=> mode == 3'd0); // R4
  AST_PSUSP_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    supply_ok && mode == 3'd5 && op_done && !op_fail |=> mode == 3'd4); // R7
  AST_FAIL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    supply_ok && running && op_fail |=> mode == 3'd6); // R8
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    supply_ok && mode == 3'd6 && !rst_wr |=> mode == 3'd6); // R8
  AST_BUSY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (running || mode == 3'd6 || mode == 3'd7) |-> rd_route == 2'd1); // R8
  AST_ERROR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    supply_ok && mode == 3'd7 && !rst_wr |=> mode == 3'd7); // R9
endmodule

bind flash_cmd_ctrl fcm_chk #(.CMD_RESET(CMD_RESET)) u_fcm_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .wr_valid(wr_valid),
  .wr_data(wr_data), .op_done(op_done), .op_fail(op_fail),
  .rd_route(rd_route), .mode(mode)
);

// File: tb/flash_cmd_ctrl_test.sv
`timescale 1ns/100ps
module flash_cmd_ctrl_test;
  localparam int AW = 11;
  localparam int SB = 2;
  localparam int NS = 1 << SB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          supply_ok = 1'b1;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          op_done = 1'b0;
  logic          op_fail = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [1:0]    rd_route;
  logic [2:0]    mode;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(AW), .SECT_BITS(SB)) uut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .op_done(op_done), .op_fail(op_fail), .rd_addr(rd_addr),
    .rd_route(rd_route), .mode(mode)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic pulse(input logic dn, input logic fl);
    @(negedge clk);
    op_done = dn; op_fail = fl;
    @(negedge clk);
    op_done = 1'b0; op_fail = 1'b0;
  endtask

  task automatic unlock();
    wr(11'h555, 8'hAA);
    wr(11'h2AA, 8'h55);
  endtask

  task automatic start_erase(input int s);
    unlock(); wr(11'h555, 8'h80); unlock();
    wr({s[SB-1:0], 9'h0C3}, 8'h30);
  endtask

  // expected route per sector: bit set -> status (1), clear -> array (0)
  task automatic chk_routes(input string tag, input logic [NS-1:0] stat_mask);
    for (int q = 0; q < NS; q++) begin
      rd_addr = {q[SB-1:0], 9'h1A5};
      #0.5;
      chk(tag, int'(rd_route), stat_mask[q] ? 1 : 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    #1;
    chk("R1 mode in reset", int'(mode), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mode after reset", int'(mode), 0);
    chk("R1 ready", int'(wr_ready), 1);
    chk_routes("R2 read routes array", '0);

    // R3 identifier mode
    unlock(); wr(11'h555, 8'h90);
    chk("R3 ident mode", int'(mode), 1);
    rd_addr = 11'h7FF; #0.5;
    chk("R3 ident route", int'(rd_route), 2);
    wr(11'h000, 8'h00); wr(11'h555, 8'hAA);
    chk("R3 other writes ignored", int'(mode), 1);
    wr(11'h123, 8'hF0);
    chk("R3 reset any address", int'(mode), 0);

    // R4 program, R8 reset ignored while running
    unlock(); wr(11'h555, 8'hA0);
    chk("R12 setup not yet program", int'(mode), 0);
    wr(11'h3AB, 8'h5A);
    chk("R4 program mode", int'(mode), 2);
    chk_routes("R4 program status", '1);
    wr(11'h000, 8'hF0);
    chk("R8 reset ignored in program", int'(mode), 2);
    pulse(1'b1, 1'b0);
    chk("R4 done to read", int'(mode), 0);

    // R5 R6 R7 R10: every sector as erase target
    for (int s = 0; s < NS; s++) begin
      logic [NS-1:0] m;
      m = '0; m[s] = 1'b1;
      start_erase(s);
      chk("R5 erase mode", int'(mode), 3);
      chk_routes("R5 erase status", '1);
      wr(11'h0F0, 8'hB0);
      chk("R6 suspended", int'(mode), 4);
      chk_routes("R6 per-sector route", m);
      unlock(); wr(11'h555, 8'hA0); wr(11'h011, 8'h3C);
      chk("R7 program in suspend", int'(mode), 5);
      chk_routes("R7 status everywhere", '1);
      pulse(1'b1, 1'b0);
      chk("R7 back to suspend", int'(mode), 4);
      chk_routes("R7 routing kept", m);
      wr(11'h555, 8'hAA); wr(11'h000, 8'hF0);
      chk("R10 reset in suspend", int'(mode), 4);
      wr(11'h000, 8'h30);
      chk("R6 resume", int'(mode), 3);
      pulse(1'b1, 1'b0);
      chk("R5 erase done", int'(mode), 0);
      chk_routes("R5 marks cleared", '0);
    end

    // R5 chip erase, R8 fail
    unlock(); wr(11'h555, 8'h80); unlock(); wr(11'h555, 8'h10);
    chk("R5 chip erase", int'(mode), 3);
    wr(11'h000, 8'hB0);
    chk_routes("R5 chip marks all", '1);
    wr(11'h000, 8'h30);
    pulse(1'b0, 1'b1);
    chk("R8 erase fail", int'(mode), 6);
    pulse(1'b1, 1'b0); wr(11'h000, 8'h00);
    chk("R8 fail sticky", int'(mode), 6);
    chk_routes("R8 fail status", '1);
    wr(11'h000, 8'hF0);
    chk("R8 reset leaves fail", int'(mode), 0);
    chk_routes("R8 marks cleared", '0);

    // R8 fail wins over done
    unlock(); wr(11'h555, 8'hA0); wr(11'h100, 8'h01);
    pulse(1'b1, 1'b1);
    chk("R8 fail priority", int'(mode), 6);
    wr(11'h000, 8'hF0);

    // R9 wrong data at each step of the erase sequence
    for (int k = 0; k < 6; k++) begin
      logic [AW-1:0] sa [6];
      logic [7:0]    sd [6];
      sa = '{11'h555, 11'h2AA, 11'h555, 11'h555, 11'h2AA, 11'h400};
      sd = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h30};
      for (int j = 0; j < k; j++) wr(sa[j], sd[j]);
      wr(11'h555, 8'h77);
      chk("R9 bad data error", int'(mode), 7);
      rd_addr = '0; #0.5;
      chk("R9 error route", int'(rd_route), 1);
      pulse(1'b1, 1'b1); wr(11'h555, 8'hAA);
      chk("R9 error sticky", int'(mode), 7);
      wr(11'h000, 8'hF0);
      chk("R9 reset leaves error", int'(mode), 0);
    end
    wr(11'h554, 8'hAA);
    chk("R9 bad address error", int'(mode), 7);
    wr(11'h000, 8'hF0);

    // R9 bad command in suspend, marks cleared after reset
    start_erase(1); wr(11'h000, 8'hB0); unlock(); wr(11'h555, 8'h90);
    chk("R9 ident refused in suspend", int'(mode), 7);
    wr(11'h000, 8'hF0);
    chk_routes("R9 marks cleared", '0);

    // R10 abandoned sequence in read mode
    wr(11'h555, 8'hAA); wr(11'h000, 8'hF0);
    chk("R10 reset mid sequence", int'(mode), 0);
    wr(11'h2AA, 8'h55);
    chk("R10 sequence restarted", int'(mode), 7);
    wr(11'h000, 8'hF0);

    // R11 pulses ignored when idle
    pulse(1'b1, 1'b1);
    chk("R11 pulses in read", int'(mode), 0);
    start_erase(2); wr(11'h000, 8'hB0);
    pulse(1'b1, 1'b1);
    chk("R11 pulses in suspend", int'(mode), 4);

    // R1 lockout
    @(negedge clk); supply_ok = 1'b0;
    @(negedge clk);
    chk("R1 lockout read", int'(mode), 0);
    chk("R1 ready low", int'(wr_ready), 0);
    unlock(); wr(11'h555, 8'h90);
    chk("R1 writes dropped", int'(mode), 0);
    @(negedge clk); supply_ok = 1'b1;
    @(negedge clk);
    chk("R1 still read", int'(mode), 0);
    chk_routes("R1 marks cleared", '0);
    unlock(); wr(11'h555, 8'h90);
    chk("R1 fresh sequence", int'(mode), 1);
    wr(11'h000, 8'hF0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule